// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the bus-facing half of a FIFO-based serial port. A host on a simple 32-bit memory-mapped bus writes characters into a transmit queue and reads received characters out of a receive queue. It also programs line framing, modem control and the bit-rate divisor, and services one interrupt line. The bit shifter and the baud generator sit outside the block. They appear only as a transmit character stream with a ready handshake, a receive character strobe, and three error pulses.

Bus accesses take one cycle. `req_i` marks an access and `we_i` selects a write. For a read, `rdata_o` is valid combinationally in the cycle of the access. Its side effects take place at the closing clock edge: popping the receive queue, clearing sticky error flags, clearing interrupt status. Offsets are word aligned: data 0x00, line status 0x04, modem status 0x08, line control 0x0C, modem control 0x10, divisor low 0x14, divisor high 0x18, interrupt control/status 0x1C, transmit level 0x20, receive level 0x24.

Top module: `uart_reg_if`

## Requirements
- R1: After reset, line status reads 0x41, both queue levels read 0, `irq_o`, `break_o`, `lcr_o` and `mcr_o` are 0.
- R2: A write to offset 0x00 appends `wdata_i[7:0]` to a 128-entry transmit queue. The head is presented on `tx_data_o` with `tx_valid_o` high and leaves on a cycle with `tx_ready_i` high. Order is preserved, and a write while 128 entries are held is dropped.
- R3: A read of offset 0x00 returns the oldest received character in bits 7:0 and removes it. A read while the receive queue is empty returns 0 and changes nothing. A `rx_valid_i` cycle appends `rx_data_i` to the 128-entry receive queue.
- R4: Line status layout: bit 0 transmit queue not full, bit 1 receive queue not empty, bit 2 parity error, bit 3 overrun, bit 4 framing error, bit 5 break seen, bit 6 transmit queue empty. Bits 2..5 are sticky and clear on a line status read; an event in the same cycle wins. Overrun is a `rx_valid_i` cycle with the receive queue full, and the character is dropped.
- R5: Offset 0x1C reads {enables in bits 7:4, 0, 0, RX status bit 1, TX status bit 0}. Writes change only bits 7:4. A status bit latches while its condition holds (receive queue not empty; transmit queue not full). A read clears both status bits at its closing edge.
- R6: `irq_o` is high when (status bit 1 and enable bit 5) or (status bit 0 and enable bit 4).
- R7: Line control is an 8-bit register driven on `lcr_o`; while its bit 5 is 1, `break_o` is 1.
- R8: Writing 0 to offset 0x24 empties the receive queue; a nonzero write there has no effect.
- R9: Modem control keeps bits 4:0 (0 DTR, 1 RTS, 2 carrier detect, 3 ring indicator, 4 loopback), reads back masked with 0x1F and drives `mcr_o`. Divisor low holds 16 bits and divisor high 8 bits, both read back and drive `div_lo_o`/`div_hi_o`. Offset 0x08 reads `msr_i`.
- R10: Offsets 0x20 and 0x24 read the current transmit and receive queue levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access in this cycle |
| we_i | input | 1 | 1 write, 0 read |
| addr_i | input | 6 | Byte offset, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid during a read access |
| tx_data_o | output | 8 | Transmit queue head |
| tx_valid_o | output | 1 | Transmit queue not empty |
| tx_ready_i | input | 1 | Shifter takes the head |
| rx_data_i | input | 8 | Received character |
| rx_valid_i | input | 1 | Received character strobe |
| rx_perr_i | input | 1 | Parity error pulse |
| rx_ferr_i | input | 1 | Framing error pulse |
| rx_brk_i | input | 1 | Break detected pulse |
| msr_i | input | 8 | Modem status inputs |
| lcr_o | output | 8 | Line control register |
| mcr_o | output | 8 | Modem control register |
| div_lo_o | output | 16 | Divisor low register |
| div_hi_o | output | 8 | Divisor high register |
| break_o | output | 1 | Force break on the transmit line |
| irq_o | output | 1 | Interrupt request |

## Verification
The checker assumes the bus issues at most one access per cycle and holds address and write data steady within it. It also assumes a flush write never coincides with a received character strobe. The stimulus drives every input once per cycle away from the clock edge, with `req_i` framing each access. Received strobes are kept apart from receive-level writes. The random phase throttles `tx_ready_i` and reads rarely, so both queues reach full and the drop and overrun paths are taken.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  localparam int REG_AW = 6;
  localparam logic [REG_AW-1:0] OFS_DATA  = 6'h00;
  localparam logic [REG_AW-1:0] OFS_LSR   = 6'h04;
  localparam logic [REG_AW-1:0] OFS_MSR   = 6'h08;
  localparam logic [REG_AW-1:0] OFS_LCR   = 6'h0C;
  localparam logic [REG_AW-1:0] OFS_MCR   = 6'h10;
  localparam logic [REG_AW-1:0] OFS_DIVL  = 6'h14;
  localparam logic [REG_AW-1:0] OFS_DIVH  = 6'h18;
  localparam logic [REG_AW-1:0] OFS_ISC   = 6'h1C;
  localparam logic [REG_AW-1:0] OFS_TXLVL = 6'h20;
  localparam logic [REG_AW-1:0] OFS_RXLVL = 6'h24;
  localparam int  LCR_BRK_BIT = 5;
  localparam logic [7:0] MCR_MASK = 8'h1F;

  typedef struct packed {
    logic brk;
    logic frm;
    logic ovr;
    logic par;
  } err_flags_t;
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 128,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign dout_o  = mem[rp_q];
  assign cnt_o   = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem[wp_q] <= din_i;
  end
endmodule

// File: rtl/uart_err_flags.sv
module uart_err_flags
  import uart_reg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  err_flags_t set_i,
  input  logic       clr_i,
  output err_flags_t flags_o
);
  err_flags_t flags_q;

  // a new event in the clearing cycle survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (clr_i ? err_flags_t'('0) : flags_q) | set_i;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/uart_irq.sv
module uart_irq (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_we_i,
  input  logic [3:0] en_wdata_i,
  input  logic       rd_clr_i,
  input  logic       rx_cond_i,
  input  logic       tx_cond_i,
  output logic [3:0] en_o,
  output logic [1:0] st_o,
  output logic       irq_o
);
  logic [3:0] en_q;
  logic [1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      if (en_we_i) en_q <= en_wdata_i;
      st_q <= rd_clr_i ? 2'b00 : (st_q | {rx_cond_i, tx_cond_i});
    end
  end

  assign en_o  = en_q;
  assign st_o  = st_q;
  assign irq_o = |(st_q & en_q[1:0]);
endmodule

// File: rtl/uart_reg_if.sv
module uart_reg_if
  import uart_reg_pkg::*;
#(
  parameter int FIFO_DEPTH = 128,
  parameter int CHAR_W     = 8,
  parameter int DATA_W     = 32,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CHAR_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  input  logic [CHAR_W-1:0] rx_data_i,
  input  logic              rx_valid_i,
  input  logic              rx_perr_i,
  input  logic              rx_ferr_i,
  input  logic              rx_brk_i,
  input  logic [7:0]        msr_i,
  output logic [7:0]        lcr_o,
  output logic [7:0]        mcr_o,
  output logic [15:0]       div_lo_o,
  output logic [7:0]        div_hi_o,
  output logic              break_o,
  output logic              irq_o
);
  logic rd, wr;
  assign rd = req_i & ~we_i;
  assign wr = req_i &  we_i;

  logic [CHAR_W-1:0] rx_dout;
  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic rx_flush;

  assign rx_flush   = wr && addr_i == OFS_RXLVL && wdata_i == '0;
  assign tx_valid_o = ~tx_empty;

  uart_fifo #(.W(CHAR_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .flush_i (1'b0),
    .push_i  (wr && addr_i == OFS_DATA),
    .din_i   (wdata_i[CHAR_W-1:0]),
    .pop_i   (tx_ready_i),
    .dout_o  (tx_data_o),
    .cnt_o   (tx_cnt),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );

  uart_fifo #(.W(CHAR_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .flush_i (rx_flush),
    .push_i  (rx_valid_i),
    .din_i   (rx_data_i),
    .pop_i   (rd && addr_i == OFS_DATA),
    .dout_o  (rx_dout),
    .cnt_o   (rx_cnt),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  err_flags_t err_set, err_flags;
  assign err_set = '{brk: rx_brk_i, frm: rx_ferr_i, ovr: rx_valid_i & rx_full, par: rx_perr_i};

  uart_err_flags u_err (
    .clk_i, .rst_ni,
    .set_i   (err_set),
    .clr_i   (rd && addr_i == OFS_LSR),
    .flags_o (err_flags)
  );

  logic [3:0] irq_en;
  logic [1:0] irq_st;

  uart_irq u_irq (
    .clk_i, .rst_ni,
    .en_we_i    (wr && addr_i == OFS_ISC),
    .en_wdata_i (wdata_i[7:4]),
    .rd_clr_i   (rd && addr_i == OFS_ISC),
    .rx_cond_i  (~rx_empty),
    .tx_cond_i  (~tx_full),
    .en_o       (irq_en),
    .st_o       (irq_st),
    .irq_o      (irq_o)
  );

  logic [7:0]  lcr_q, mcr_q, divh_q;
  logic [15:0] divl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcr_q  <= '0;
      mcr_q  <= '0;
      divl_q <= '0;
      divh_q <= '0;
    end else if (wr) begin
      case (addr_i)
        OFS_LCR:  lcr_q  <= wdata_i[7:0];
        OFS_MCR:  mcr_q  <= wdata_i[7:0] & MCR_MASK;
        OFS_DIVL: divl_q <= wdata_i[15:0];
        OFS_DIVH: divh_q <= wdata_i[7:0];
        default: ;
      endcase
    end
  end

  assign lcr_o    = lcr_q;
  assign mcr_o    = mcr_q;
  assign div_lo_o = divl_q;
  assign div_hi_o = divh_q;
  assign break_o  = lcr_q[LCR_BRK_BIT];

  logic [7:0] lsr;
  assign lsr = {1'b0, tx_empty, err_flags, ~rx_empty, ~tx_full};

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (addr_i)
        OFS_DATA:  rdata_o = rx_empty ? '0 : DATA_W'(rx_dout);
        OFS_LSR:   rdata_o = DATA_W'(lsr);
        OFS_MSR:   rdata_o = DATA_W'(msr_i);
        OFS_LCR:   rdata_o = DATA_W'(lcr_q);
        OFS_MCR:   rdata_o = DATA_W'(mcr_q);
        OFS_DIVL:  rdata_o = DATA_W'(divl_q);
        OFS_DIVH:  rdata_o = DATA_W'(divh_q);
        OFS_ISC:   rdata_o = DATA_W'({irq_en, 2'b00, irq_st});
        OFS_TXLVL: rdata_o = DATA_W'(tx_cnt);
        OFS_RXLVL: rdata_o = DATA_W'(rx_cnt);
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_reg_if_chk.sv
module uart_reg_if_chk
  import uart_reg_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [REG_AW-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic [CW-1:0]     tx_cnt,
  input logic [CW-1:0]     rx_cnt,
  input logic [1:0]        irq_st,
  input logic [3:0]        irq_en,
  input logic [3:0]        err_flags,
  input logic              irq_o,
  input logic              break_o
);
  a_r2_tx_cnt_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt <= CW'(DEPTH));

  a_r2_tx_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFS_DATA && tx_cnt == CW'(DEPTH) && !(tx_valid_o && tx_ready_i))
      |=> tx_cnt == CW'(DEPTH));

  a_r4_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i && addr_i == OFS_LSR) |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  a_r5_isc_rd_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == OFS_ISC) |=> irq_st == 2'b00);

  a_r6_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en[1:0] == 2'b00) |-> !irq_o);

  a_r7_break_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFS_LCR && wdata_i[LCR_BRK_BIT]) |=> break_o);

  a_r8_rx_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFS_RXLVL && wdata_i == 32'd0) |=> rx_cnt == '0);
endmodule

bind uart_reg_if uart_reg_if_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .tx_cnt     (tx_cnt),
  .rx_cnt     (rx_cnt),
  .irq_st     (irq_st),
  .irq_en     (irq_en),
  .err_flags  (err_flags),
  .irq_o      (irq_o),
  .break_o    (break_o)
);

// File: tb/uart_reg_if_bench.sv
module uart_reg_if_bench;
  localparam int DEPTH = 128;
  localparam logic [5:0] A_DATA = 6'h00, A_LSR = 6'h04, A_MSR = 6'h08, A_LCR = 6'h0C,
    A_MCR = 6'h10, A_DIVL = 6'h14, A_DIVH = 6'h18, A_ISC = 6'h1C, A_TXL = 6'h20, A_RXL = 6'h24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [7:0] tx_data, rx_data = '0, msr = '0, lcr, mcr, div_hi;
  logic [15:0] div_lo;
  logic tx_valid, tx_ready = 0, rx_valid = 0, perr = 0, ferr = 0, brk = 0, brk_o, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_reg_if u_uart_reg_if (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .rx_data_i(rx_data), .rx_valid_i(rx_valid), .rx_perr_i(perr), .rx_ferr_i(ferr),
    .rx_brk_i(brk), .msr_i(msr), .lcr_o(lcr), .mcr_o(mcr), .div_lo_o(div_lo),
    .div_hi_o(div_hi), .break_o(brk_o), .irq_o(irq)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    cyc();
    req = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    req = 1; we = 0; addr = a;
    #1 d = rdata;
    cyc();
    req = 0;
  endtask

  task automatic rd_chk(input string r, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    chk(r, d, exp);
  endtask

  function automatic logic [31:0] lsr_exp(input int tq, input int rq, input logic [3:0] ef);
    return {25'd0, tq == 0, ef, rq != 0, tq < DEPTH};
  endfunction

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0] tq[$];
    logic [7:0] rq[$];
    logic [3:0] ef;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc();

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 break", {31'd0, brk_o}, 0);
    chk("R1 lcr/mcr", {16'd0, lcr, mcr}, 0);
    rd_chk("R1 lsr", A_LSR, 32'h41);
    rd_chk("R1 txlvl", A_TXL, 0);
    rd_chk("R1 rxlvl", A_RXL, 0);

    // R2 fill transmit queue past capacity
    tx_ready = 0;
    for (int i = 0; i < DEPTH + 2; i++) bus_wr(A_DATA, i);
    rd_chk("R10 txlvl full", A_TXL, DEPTH);
    rd_chk("R4 lsr tx full", A_LSR, 32'h00);
    tx_ready = 1;
    for (int i = 0; i < DEPTH; i++) begin
      #1;
      chk("R2 tx order", {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, 8'(i)});
      cyc();
    end
    #1 chk("R2 extra dropped", {31'd0, tx_valid}, 0);

    // R3/R4 receive fill and overrun
    for (int i = 0; i < DEPTH + 1; i++) begin
      rx_valid = 1; rx_data = 8'(i + 3);
      cyc();
    end
    rx_valid = 0;
    rd_chk("R10 rxlvl full", A_RXL, DEPTH);
    rd_chk("R4 overrun", A_LSR, 32'h4B);
    rd_chk("R4 cleared on read", A_LSR, 32'h43);
    rd_chk("R3 rx head", A_DATA, 3);
    bus_wr(A_RXL, 5);
    rd_chk("R8 nonzero ignored", A_RXL, DEPTH - 1);
    bus_wr(A_RXL, 0);
    rd_chk("R8 flushed", A_RXL, 0);
    rd_chk("R8 lsr after flush", A_LSR, 32'h41);
    rd_chk("R3 empty read", A_DATA, 0);
    rd_chk("R3 empty read no effect", A_RXL, 0);

    // R5/R6 interrupt logic
    chk("R6 disabled", {31'd0, irq}, 0);
    bus_wr(A_ISC, 32'h0F);
    rd_chk("R5 status latched", A_ISC, 32'h03);
    rd_chk("R5 cleared by read", A_ISC, 32'h00);
    cyc();
    rd_chk("R5 tx status relatch", A_ISC, 32'h01);
    bus_wr(A_ISC, 32'h10);
    chk("R6 tx irq", {31'd0, irq}, 1);
    rd_chk("R5 enables", A_ISC, 32'h11);
    chk("R6 irq after clear", {31'd0, irq}, 0);
    cyc();
    chk("R6 irq relatch", {31'd0, irq}, 1);
    bus_wr(A_ISC, 32'h20);
    chk("R6 rx masked tx", {31'd0, irq}, 0);
    rx_valid = 1; rx_data = 8'h5A;
    cyc();
    rx_valid = 0;
    cyc();
    chk("R6 rx irq", {31'd0, irq}, 1);
    rd_chk("R3 rx byte", A_DATA, 32'h5A);
    chk("R6 rx status sticky", {31'd0, irq}, 1);
    rd_chk("R5 rx status", A_ISC, 32'h23);
    chk("R6 rx irq cleared", {31'd0, irq}, 0);
    cyc();
    chk("R6 rx stays low", {31'd0, irq}, 0);
    bus_wr(A_ISC, 0);

    // R7 line control
    bus_wr(A_LCR, 32'h3B);
    chk("R7 break on", {23'd0, brk_o, lcr}, {23'd0, 1'b1, 8'h3B});
    bus_wr(A_LCR, 32'h1B);
    chk("R7 break off", {31'd0, brk_o}, 0);
    rd_chk("R7 lcr read", A_LCR, 32'h1B);

    // R9 modem control, divisor, modem status
    bus_wr(A_MCR, 32'hFF);
    rd_chk("R9 mcr mask", A_MCR, 32'h1F);
    chk("R9 mcr_o", {24'd0, mcr}, 32'h1F);
    bus_wr(A_DIVL, 32'hFFFF_F0AB);
    rd_chk("R9 div lo", A_DIVL, 32'hF0AB);
    bus_wr(A_DIVH, 32'h1234);
    rd_chk("R9 div hi", A_DIVH, 32'h34);
    chk("R9 div outs", {div_hi, div_lo}, 32'h0034_F0AB);
    msr = 8'hA5;
    rd_chk("R9 msr", A_MSR, 32'hA5);

    // R4 error pulses
    perr = 1; cyc(); perr = 0;
    rd_chk("R4 parity", A_LSR, 32'h45);
    ferr = 1; cyc(); ferr = 0;
    brk = 1; cyc(); brk = 0;
    rd_chk("R4 frame+break", A_LSR, 32'h71);
    rd_chk("R4 cleared", A_LSR, 32'h41);

    // random phase against a queue model
    ef = '0;
    for (int n = 0; n < 4000; n++) begin
      int op;
      bit wr_d, rd_d, rd_l, txp, rxf;
      op = $urandom % 6;
      wr_d = (op < 2); rd_d = (op == 2); rd_l = (op == 3);
      tx_ready = ($urandom % 4 == 0);
      rx_valid = ($urandom % 3 == 0);
      rx_data = 8'($urandom);
      perr = ($urandom % 32 == 0);
      ferr = ($urandom % 32 == 0);
      brk = ($urandom % 32 == 0);
      req = wr_d | rd_d | rd_l; we = wr_d;
      addr = rd_l ? A_LSR : A_DATA;
      wdata = $urandom;
      #1;
      chk("R2 tx valid", {31'd0, tx_valid}, {31'd0, tq.size() != 0});
      if (tq.size() != 0) chk("R2 tx head", {24'd0, tx_data}, {24'd0, tq[0]});
      if (rd_d) chk("R3 rx read", rdata, rq.size() != 0 ? {24'd0, rq[0]} : 32'd0);
      if (rd_l) chk("R4 lsr", rdata, lsr_exp(tq.size(), rq.size(), ef));
      txp = tx_ready && tq.size() != 0;
      if (txp) void'(tq.pop_front());
      if (wr_d && tq.size() + (txp ? 1 : 0) < DEPTH) tq.push_back(wdata[7:0]);
      rxf = rq.size() >= DEPTH;
      if (rd_d && rq.size() != 0) void'(rq.pop_front());
      if (rx_valid && !rxf) rq.push_back(rx_data);
      ef = (rd_l ? 4'd0 : ef) | {brk, ferr, rx_valid & rxf, perr};
      cyc();
      req = 0; we = 0; rx_valid = 0; perr = 0; ferr = 0; brk = 0;
    end
    rd_chk("R10 txlvl model", A_TXL, tq.size());
    rd_chk("R10 rxlvl model", A_RXL, rq.size());

    done = 1;
    report();
  end
endmodule